// File: doc/BRIEF.md
# Modulo Counter Wake-Up Timer

A bus-attached timer that raises a wake-up interrupt after a programmed number of ticks. The counter is 16 bits wide. Its tick comes from one of three sources: the system clock, a slow fixed-rate strobe of about 32 kHz, or an external strobe. The tick then passes through a power-of-two divider. The counter runs upward from a programmable start value to a programmable limit and jumps back to the start value on the tick after it reaches the limit. That jump sets a sticky flag. When the enable bit is set, the flag drives a level interrupt.

Software arms an alarm in four steps: choose the source and the divider, program the limit as N-1 and the start value, write anything to the counter to restart it, and set the interrupt enable. The flag then rises exactly N divided ticks later. Clearing the flag takes a read of the control word that shows the flag set, followed by a write of 0 to the flag bit. A wrap that lands in the same cycle as the clearing write wins, so the event is never lost.

Top module: `wake_timer`

## Requirements
- R1: After reset the control word reads 0, the counter reads 0, the limit register reads 0xFFFF, the start register reads 0 and `irq` is low.
- R2: The bus uses word addresses 0 (control), 1 (counter), 2 (limit) and 3 (start value). Read data appears on `bus_rdata` in the cycle after the request. The counter, limit and start registers hold 16 bits, and their upper 16 bits read as zero. Control bits are: [2:0] divider exponent, [4:3] source, [5] interrupt enable, [6] flag.
- R3: Source code 0 stops counting. Code 1 ticks on every clock. Code 2 ticks on `fixed_tick`. Code 3 ticks on `ext_tick`. Strobes from a source that is not selected have no effect.
- R4: With divider exponent k, the counter advances once for every 2^k events of the selected source.
- R5: On each divided tick the counter increments while it differs from the limit. On the tick where it equals the limit, it reloads the start value.
- R6: Any write to the counter address loads the start value and ignores the write data.
- R7: The flag is set on the reload tick. With limit N-1 and start 0, the flag first rises on the Nth divided tick after a counter write.
- R8: A write of 0 to the flag bit clears the flag only if a control read has returned the flag as 1 since the last control write. A write of 1 to the flag bit, or a write of 0 without that read, leaves the flag set.
- R9: If a reload tick coincides with the clearing write, the flag stays set.
- R10: `irq` is registered and equals flag AND enable one cycle later.
- R11: New source and divider settings take effect at the next divider boundary. While the programmed source is 0, the divider count is held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fixed_tick | input | 1 | Fixed-rate strobe, one cycle per event |
| ext_tick | input | 1 | External strobe, one cycle per event |
| bus_sel | input | 1 | Bus request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| irq | output | 1 | Level interrupt |

## Verification
The counter is driven by every clock, by single strobe pulses, and by groups of pulses under a divider of 4. These runs separate a correct source select and divider from off-by-one boundaries and from strobes leaking in from a source that is not selected. The start and limit registers are tested with a non-zero start, which separates reload-to-start from reload-to-zero. The flag is checked one tick before and exactly at the Nth tick. The clear protocol is tried four ways: writing 1, writing 0 without a read, writing 0 during a wrap, and a proper read-then-clear.

// File: rtl/wake_timer_pkg.sv
package wake_timer_pkg;
  typedef enum logic [1:0] {
    SRC_OFF   = 2'd0,
    SRC_SYS   = 2'd1,
    SRC_FIXED = 2'd2,
    SRC_EXT   = 2'd3
  } src_e;

  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_COUNT = 2'd1,
    REG_LIMIT = 2'd2,
    REG_START = 2'd3
  } reg_e;
endpackage

// File: rtl/wt_prescaler.sv
module wt_prescaler
  import wake_timer_pkg::*;
#(
  parameter int PS_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  src_e            src_prog,
  input  logic [PS_W-1:0] ps_prog,
  input  logic            fixed_tick,
  input  logic            ext_tick,
  output logic            tick
);
  localparam int DIV_W = (1 << PS_W) - 1;

  src_e             src_act;
  logic [PS_W-1:0]  ps_act;
  logic [DIV_W-1:0] pcnt;
  logic [DIV_W-1:0] mask;
  logic             src_hit;

  assign mask = {DIV_W{1'b1}} >> (PS_W'(DIV_W) - ps_act);

  always_comb begin
    case (src_act)
      SRC_SYS:   src_hit = 1'b1;
      SRC_FIXED: src_hit = fixed_tick;
      SRC_EXT:   src_hit = ext_tick;
      default:   src_hit = 1'b0;
    endcase
  end

  assign tick = src_hit && (pcnt == mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt    <= '0;
      src_act <= SRC_OFF;
      ps_act  <= '0;
    end else if (src_prog == SRC_OFF || src_act == SRC_OFF) begin
      pcnt    <= '0;
      src_act <= src_prog;
      ps_act  <= ps_prog;
    end else if (src_hit) begin
      if (pcnt == mask) begin
        pcnt    <= '0;
        src_act <= src_prog;
        ps_act  <= ps_prog;
      end else begin
        pcnt <= pcnt + DIV_W'(1);
      end
    end
  end

  // R11: a stopped source holds the divider at zero and produces no tick
  a_r11_stop_clears: assert property (@(posedge clk) disable iff (rst)
    (src_prog == SRC_OFF) |=> (pcnt == '0 && !tick));
endmodule

// File: rtl/wt_counter.sv
module wt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             reload_wr,
  input  logic [CNT_W-1:0] start_val,
  input  logic [CNT_W-1:0] limit_val,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  assign wrap = tick && !reload_wr && (cnt == limit_val);

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (reload_wr || wrap)
      cnt <= start_val;
    else if (tick)
      cnt <= cnt + CNT_W'(1);
  end

  // R6: counter write loads the start value
  a_r6_reload: assert property (@(posedge clk) disable iff (rst)
    reload_wr |=> (cnt == $past(start_val)));
  // R5: reaching the limit reloads the start value
  a_r5_wrap: assert property (@(posedge clk) disable iff (rst)
    (tick && !reload_wr && cnt == limit_val) |=> (cnt == $past(start_val)));
  // R5: below the limit a tick steps by one
  a_r5_step: assert property (@(posedge clk) disable iff (rst)
    (tick && !reload_wr && cnt != limit_val) |=> (cnt == $past(cnt) + CNT_W'(1)));
endmodule

// File: rtl/wt_flag.sv
module wt_flag (
  input  logic clk,
  input  logic rst,
  input  logic wrap,
  input  logic rd_stat,
  input  logic wr_stat,
  input  logic wr_flag_bit,
  input  logic ie,
  output logic flag,
  output logic irq
);
  logic armed;
  logic clear_ok;

  assign clear_ok = wr_stat && !wr_flag_bit && armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag  <= 1'b0;
      armed <= 1'b0;
      irq   <= 1'b0;
    end else begin
      if (wrap)          flag <= 1'b1;
      else if (clear_ok) flag <= 1'b0;
      if (wr_stat)               armed <= 1'b0;
      else if (rd_stat && flag)  armed <= 1'b1;
      irq <= flag && ie;
    end
  end

  // R7/R9: a wrap always leaves the flag set, even against a clear
  a_r9_wrap_sets: assert property (@(posedge clk) disable iff (rst)
    wrap |=> flag);
  // R8: without a clearing write the flag holds
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (flag && !(wr_stat && !wr_flag_bit)) |=> flag);
  // R8: without a prior read the flag cannot be cleared
  a_r8_needs_read: assert property (@(posedge clk) disable iff (rst)
    (flag && !armed) |=> flag);
  // R10: with the enable low the interrupt is low next cycle
  a_r10_gate: assert property (@(posedge clk) disable iff (rst)
    !ie |=> !irq);
endmodule

// File: rtl/wake_timer.sv
module wake_timer
  import wake_timer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PS_W   = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fixed_tick,
  input  logic              ext_tick,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int SRC_LO = PS_W;
  localparam int IE_BIT = PS_W + 2;
  localparam int FL_BIT = PS_W + 3;
  localparam int CTL_W  = PS_W + 4;

  src_e             src_q;
  logic [PS_W-1:0]  ps_q;
  logic             ie_q;
  logic [CNT_W-1:0] limit_q;
  logic [CNT_W-1:0] start_q;
  logic [CNT_W-1:0] cnt;
  logic             tick;
  logic             wrap;
  logic             flag;
  logic             wr_ctrl, rd_ctrl, wr_count;
  logic             unused_wdata;

  assign unused_wdata = ^bus_wdata[DATA_W-1:CTL_W];
  assign wr_ctrl  = bus_sel && bus_we  && (reg_e'(bus_addr) == REG_CTRL);
  assign rd_ctrl  = bus_sel && !bus_we && (reg_e'(bus_addr) == REG_CTRL);
  assign wr_count = bus_sel && bus_we  && (reg_e'(bus_addr) == REG_COUNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q   <= SRC_OFF;
      ps_q    <= '0;
      ie_q    <= 1'b0;
      limit_q <= '1;
      start_q <= '0;
    end else if (bus_sel && bus_we) begin
      case (reg_e'(bus_addr))
        REG_CTRL: begin
          ps_q  <= bus_wdata[PS_W-1:0];
          src_q <= src_e'(bus_wdata[SRC_LO+1:SRC_LO]);
          ie_q  <= bus_wdata[IE_BIT];
        end
        REG_LIMIT: limit_q <= bus_wdata[CNT_W-1:0];
        REG_START: start_q <= bus_wdata[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      bus_rdata <= '0;
    else if (bus_sel && !bus_we) begin
      case (reg_e'(bus_addr))
        REG_CTRL:  bus_rdata <= DATA_W'({flag, ie_q, src_q, ps_q});
        REG_COUNT: bus_rdata <= DATA_W'(cnt);
        REG_LIMIT: bus_rdata <= DATA_W'(limit_q);
        default:   bus_rdata <= DATA_W'(start_q);
      endcase
    end
  end

  wt_prescaler #(.PS_W(PS_W)) u_div (
    .clk(clk), .rst(rst), .src_prog(src_q), .ps_prog(ps_q),
    .fixed_tick(fixed_tick), .ext_tick(ext_tick), .tick(tick)
  );

  wt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .reload_wr(wr_count),
    .start_val(start_q), .limit_val(limit_q), .cnt(cnt), .wrap(wrap)
  );

  wt_flag u_flag (
    .clk(clk), .rst(rst), .wrap(wrap), .rd_stat(rd_ctrl), .wr_stat(wr_ctrl),
    .wr_flag_bit(bus_wdata[FL_BIT]), .ie(ie_q), .flag(flag), .irq(irq)
  );

  // R1: interrupt is low in the cycle after reset
  a_r1_irq_reset: assert property (@(posedge clk) rst |=> !irq);
endmodule

// File: tb/wake_timer_test.sv
module wake_timer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fixed_tick = 1'b0, ext_tick = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_checks = 0, n_fail = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        mon_go = 1'b0;

  always #4 clk = ~clk;

  wake_timer uut (
    .clk(clk), .rst(rst), .fixed_tick(fixed_tick), .ext_tick(ext_tick),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic logic [31:0] ctl(input logic fl, input logic ie,
                                      input logic [1:0] src, input logic [2:0] ps);
    return {25'd0, fl, ie, src, ps};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) mon_go <= bus_sel && !bus_we;

  always @(negedge clk) begin
    if (mon_go) begin
      if (exp_q.size() == 0) check("scoreboard-empty", 32'd1, 32'd0);
      else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  task automatic idle();
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; ext_tick = 1'b0; fixed_tick = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic with_ext = 1'b0);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    ext_tick = with_ext; fixed_tick = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    ext_tick = 1'b0; fixed_tick = 1'b0;
    exp_q.push_back(e); tag_q.push_back(tag);
  endtask

  task automatic pulse(input int n, input logic fixed = 1'b0);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
      ext_tick = !fixed; fixed_tick = fixed;
      idle();
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    report();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    check("R1 irq after reset", {31'd0, irq}, 32'd0);
    rd(2'd0, 32'h0, "R1 control reset");
    rd(2'd1, 32'h0, "R1 counter reset");
    rd(2'd2, 32'h0000FFFF, "R1 limit reset");
    rd(2'd3, 32'h0, "R1 start reset");
    // R2: upper bits dropped and read as zero
    wr(2'd3, 32'h00012345);
    rd(2'd3, 32'h00002345, "R2 start readback width");
    wr(2'd3, 32'h0);
    // R3 system clock source, R6 data ignored on counter write
    wr(2'd0, ctl(1, 0, 2'd1, 3'd0));
    wr(2'd1, 32'h0000DEAD);
    repeat (9) idle();
    wr(2'd0, ctl(1, 0, 2'd0, 3'd0));
    rd(2'd1, 32'd10, "R3 R6 system clock count");
    // R3 fixed source ignores external strobe
    wr(2'd0, ctl(1, 0, 2'd2, 3'd0));
    wr(2'd1, 32'h0);
    pulse(3);
    pulse(2, 1'b1);
    rd(2'd1, 32'd2, "R3 fixed source only");
    wr(2'd0, ctl(1, 0, 2'd0, 3'd0));
    // R4 divide by 4
    wr(2'd0, ctl(1, 0, 2'd3, 3'd2));
    wr(2'd1, 32'h0);
    pulse(7);
    rd(2'd1, 32'd1, "R4 seven events");
    pulse(1);
    rd(2'd1, 32'd2, "R4 eight events");
    // R11 divider change waits for boundary
    wr(2'd1, 32'h0);
    pulse(2);
    wr(2'd0, ctl(1, 0, 2'd3, 3'd0));
    pulse(2);
    rd(2'd1, 32'd1, "R11 old divider until boundary");
    pulse(1);
    rd(2'd1, 32'd2, "R11 new divider after boundary");
    wr(2'd0, ctl(1, 0, 2'd0, 3'd0));
    // R5 reload to non-zero start
    wr(2'd3, 32'd5);
    wr(2'd2, 32'd7);
    wr(2'd0, ctl(1, 0, 2'd3, 3'd0));
    wr(2'd1, 32'h0);
    rd(2'd1, 32'd5, "R6 counter write loads start");
    pulse(2);
    rd(2'd1, 32'd7, "R5 at limit");
    pulse(1);
    rd(2'd1, 32'd5, "R5 reload start");
    wr(2'd0, ctl(1, 0, 2'd0, 3'd0));
    rd(2'd0, ctl(1, 0, 2'd0, 3'd0), "R7 flag after wrap");
    wr(2'd0, ctl(0, 0, 2'd0, 3'd0));
    rd(2'd0, 32'h0, "R8 read then clear");
    // R7 period N=5
    wr(2'd3, 32'd0);
    wr(2'd2, 32'd4);
    wr(2'd0, ctl(1, 1, 2'd3, 3'd0));
    wr(2'd1, 32'h0);
    pulse(4);
    idle();
    check("R7 irq before Nth tick", {31'd0, irq}, 32'd0);
    rd(2'd0, ctl(0, 1, 2'd3, 3'd0), "R7 flag low before Nth tick");
    pulse(1);
    idle(); idle();
    check("R10 irq at Nth tick", {31'd0, irq}, 32'd1);
    rd(2'd0, ctl(1, 1, 2'd3, 3'd0), "R7 flag at Nth tick");
    rd(2'd1, 32'd0, "R7 counter reloaded");
    // R8 writing 1, writing 0 without read
    wr(2'd0, ctl(1, 1, 2'd3, 3'd0));
    wr(2'd0, ctl(0, 1, 2'd3, 3'd0));
    rd(2'd0, ctl(1, 1, 2'd3, 3'd0), "R8 clear without read ignored");
    // R9 collision
    pulse(4);
    wr(2'd0, ctl(0, 1, 2'd3, 3'd0), 1'b1);
    idle();
    rd(2'd0, ctl(1, 1, 2'd3, 3'd0), "R9 collision keeps flag");
    wr(2'd0, ctl(0, 1, 2'd3, 3'd0));
    idle(); idle();
    check("R10 irq drops after clear", {31'd0, irq}, 32'd0);
    rd(2'd0, ctl(0, 1, 2'd3, 3'd0), "R8 cleared after read");
    wr(2'd0, ctl(1, 0, 2'd0, 3'd0));
    idle(); idle();
    check("R2 scoreboard drained", exp_q.size(), 32'd0);
    report();
  end
endmodule